// File: doc/BRIEF.md
# Flash Program/Erase Access Guard

This block is the register front end that stands between software and the program/erase engine of an on-chip flash array. Software writes bytes into a small register window. A write to the command location, combined with writes to the page location, walks a lock state machine. The page number must be written once before two fixed key bytes and once after them. The machine unlocks only if both page writes carry the same value and the page does not fall in a sector that software has marked as protected.

Once unlocked, a single program or erase command starts the flash operation. This only happens if a nonzero 16-bit clock-divider value has already been loaded. A behavioural done strobe from the flash side ends the operation, and the block then relocks.

Two locations are aliased. Reading the command location returns a 3-bit state code. The page location normally holds the page number, but it switches to the sticky sector-protect mask for exactly one access after the protect-select code is written while locked.

Top module: `flash_access_guard`

## Requirements
- R1: After reset the state code reads 0 (locked), the protect mask, the page and both divider bytes read 0, and `flash_start` is low.
- R2: While locked, writing 73h to the command location (address 0) moves to state code 1 (first key seen); any other command byte leaves the code at 0.
- R3: In state 1, writing 8Ch to the command location gives code 2 (second key seen). Any other command byte, or any page write, returns the code to 0.
- R4: In state 2, a page write (address 1) whose value equals the stored page, with its sector unprotected, gives code 3 (unlocked). A different page value gives code 0, as does any command write in state 2.
- R5: The sector of a page is its top SECT_W bits. If that sector's bit is set in the protect mask, the final page write returns the code to 0 instead of unlocking.
- R6: Reading address 0 returns the state code in bits 2:0 with bits 7:3 zero; codes are 0 locked, 1 first key, 2 second key, 3 unlocked, 4 programming, 5 erasing.
- R7: While locked, writing 5Eh to the command location points the page location at the protect mask for the next page-location access. Reads return the mask, and the next write ORs into the mask and then restores the normal page target. Otherwise the page location reads and writes the page number.
- R8: Protect mask bits are only ever set; writing zeros through the aliased location does not clear a set bit until reset.
- R9: When unlocked with a nonzero divider value (high byte at address 2, low byte at address 3), command 4Ah gives code 4 and command B5h gives code 5. Either one pulses `flash_start` for exactly one cycle, drives `flash_page` with the stored page, and sets `flash_erase` high only for the erase command.
- R10: While the code is 4 or 5, register writes do not change the state or the page; `flash_done` returns the code to 0.
- R11: A program or erase command issued while the divider value is zero returns the code to 0 without pulsing `flash_start`.
- R12: When unlocked, any other command byte, or a page write, returns the code to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register location: 0 command/state, 1 page/protect, 2 divider high, 3 divider low |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| flash_start | output | 1 | One-cycle start pulse to the flash engine |
| flash_erase | output | 1 | High while an erase operation is in progress |
| flash_page | output | PAGE_W | Page number the operation targets |
| flash_done | input | 1 | Operation finished strobe from the flash engine |

## Verification
The bench builds the block with PAGE_W = 6 and SECT_W = 2, so there are 64 pages in four sectors of sixteen. The sector index then sits in page bits 5:4, which lets the bench choose a protected page and an unprotected page within a handful of writes. With only four sectors, the whole protect mask fits in the low nibble of a read. This brings the sticky-mask behaviour and every unlock path, including protection rejects and page mismatches, within reach of short directed sequences.

// File: rtl/flash_guard_pkg.sv
// Package: shared constants and state encoding for the flash access guard.
// Assumes an 8-bit register window with four locations.
package flash_guard_pkg;

    localparam int BYTE_W = 8;
    localparam int LOC_W  = 2;

    // Register window locations.
    localparam logic [LOC_W-1:0] LOC_CMD   = 2'd0;
    localparam logic [LOC_W-1:0] LOC_PAGE  = 2'd1;
    localparam logic [LOC_W-1:0] LOC_DIVHI = 2'd2;
    localparam logic [LOC_W-1:0] LOC_DIVLO = 2'd3;

    // Command bytes.
    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h73;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'h8C;
    localparam logic [BYTE_W-1:0] CMD_PROSEL = 8'h5E;
    localparam logic [BYTE_W-1:0] CMD_PROG   = 8'h4A;
    localparam logic [BYTE_W-1:0] CMD_ERASE  = 8'hB5;

    localparam int CODE_W = 3;

    // Lock machine states; the encoding is the status code read back.
    typedef enum logic [CODE_W-1:0] {
        GS_LOCKED = 3'd0,
        GS_KEY1   = 3'd1,
        GS_KEY2   = 3'd2,
        GS_OPEN   = 3'd3,
        GS_PROG   = 3'd4,
        GS_ERASE  = 3'd5
    } guard_state_t;

endpackage

// File: rtl/flash_guard_divider.sv
// Module: holds the 16-bit flash clock divider value as two byte registers
// and reports whether it has been configured (nonzero).
// Assumes writes are single-cycle strobes already decoded by location.
module flash_guard_divider
    import flash_guard_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_wr,
    input  logic              lo_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] hi_q,
    output logic [BYTE_W-1:0] lo_q,
    output logic              div_ok
);

    localparam int HI_W = DIV_W - BYTE_W;

    logic [HI_W-1:0]   hi_r;
    logic [BYTE_W-1:0] lo_r;

    // Capture the divider bytes on their own write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_r <= '0;
            lo_r <= '0;
        end else begin
            if (hi_wr) hi_r <= wdata[HI_W-1:0];
            if (lo_wr) lo_r <= wdata;
        end
    end

    // Present the bytes and the configured flag.
    always_comb begin
        hi_q   = BYTE_W'(hi_r);
        lo_q   = lo_r;
        div_ok = ({hi_r, lo_r} != '0);
    end

endmodule

// File: rtl/flash_guard_pagereg.sv
// Module: stores the selected page number and the sticky sector protect
// mask that share one register location. Reports whether the page value
// on the write bus falls in a protected sector.
// Assumes SECT_W <= 3 so the mask fits in one byte and SECT_W <= PAGE_W.
module flash_guard_pagereg
    import flash_guard_pkg::*;
#(
    parameter int PAGE_W = 7,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_load,
    input  logic              mask_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PAGE_W-1:0] page_q,
    output logic [BYTE_W-1:0] mask_q,
    output logic              sect_hit
);

    localparam int NSECT = 1 << SECT_W;

    logic [PAGE_W-1:0] page_r;
    logic [NSECT-1:0]  mask_r;
    logic [PAGE_W-1:0] wpage;
    logic [SECT_W-1:0] wsect;

    // Extract the page on the bus and its sector index.
    always_comb begin
        wpage = wdata[PAGE_W-1:0];
        wsect = wpage[PAGE_W-1 -: SECT_W];
    end

    // Hold the last accepted page number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_r <= '0;
        end else if (page_load) begin
            page_r <= wpage;
        end
    end

    // One sticky bit per sector: set by a mask write, cleared only by reset.
    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_r[s] <= 1'b0;
            end else if (mask_wr && wdata[s]) begin
                mask_r[s] <= 1'b1;
            end
        end
    end

    // Present stored values and the protection lookup.
    always_comb begin
        page_q   = page_r;
        mask_q   = BYTE_W'(mask_r);
        sect_hit = mask_r[wsect];
    end

    // A set protect bit never falls back to zero while out of reset.
    assert_mask_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mask_r) & ~mask_r) == '0));

endmodule

// File: rtl/flash_guard_fsm.sv
// Module: the lock state machine. Consumes decoded command and page writes,
// walks the two-key unlock sequence, checks the page match and protection,
// launches program or erase and waits for the done strobe.
// Assumes at most one of cmd_wr / page_wr is high in a cycle.
module flash_guard_fsm
    import flash_guard_pkg::*;
#(
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              page_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [PAGE_W-1:0] page_q,
    input  logic              sect_hit,
    input  logic              div_ok,
    input  logic              op_done,
    output guard_state_t      state,
    output logic              prosel,
    output logic              page_load,
    output logic              mask_wr,
    output logic              op_start
);

    guard_state_t state_r;
    guard_state_t state_n;
    logic         prosel_r;
    logic         prosel_n;
    logic         start_n;
    logic         page_same;
    logic         is_run_cmd;

    // Compare the page on the bus with the one captured before the keys.
    always_comb begin
        page_same  = (wdata[PAGE_W-1:0] == page_q);
        is_run_cmd = (wdata == CMD_PROG) || (wdata == CMD_ERASE);
    end

    // Next-state logic for the lock sequence and operation launch.
    always_comb begin
        state_n  = state_r;
        prosel_n = prosel_r;
        start_n  = 1'b0;
        case (state_r)
            GS_LOCKED: begin
                if (cmd_wr) begin
                    prosel_n = (wdata == CMD_PROSEL);
                    if (wdata == KEY_FIRST) state_n = GS_KEY1;
                end else if (page_wr) begin
                    prosel_n = 1'b0;
                end
            end
            GS_KEY1: begin
                if (cmd_wr) begin
                    state_n = (wdata == KEY_SECOND) ? GS_KEY2 : GS_LOCKED;
                end else if (page_wr) begin
                    state_n = GS_LOCKED;
                end
            end
            GS_KEY2: begin
                if (cmd_wr) begin
                    state_n = GS_LOCKED;
                end else if (page_wr) begin
                    state_n = (page_same && !sect_hit) ? GS_OPEN : GS_LOCKED;
                end
            end
            GS_OPEN: begin
                if (cmd_wr) begin
                    if (is_run_cmd && div_ok) begin
                        state_n = (wdata == CMD_ERASE) ? GS_ERASE : GS_PROG;
                        start_n = 1'b1;
                    end else begin
                        state_n = GS_LOCKED;
                    end
                end else if (page_wr) begin
                    state_n = GS_LOCKED;
                end
            end
            GS_PROG, GS_ERASE: begin
                if (op_done) state_n = GS_LOCKED;
            end
            default: state_n = GS_LOCKED;
        endcase
    end

    // State, protect-select flag and start pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r  <= GS_LOCKED;
            prosel_r <= 1'b0;
            op_start <= 1'b0;
        end else begin
            state_r  <= state_n;
            prosel_r <= prosel_n;
            op_start <= start_n;
        end
    end

    // Route page-location writes to the page or to the protect mask.
    always_comb begin
        state     = state_r;
        prosel    = prosel_r;
        mask_wr   = page_wr && prosel_r;
        page_load = page_wr && !prosel_r &&
                    ((state_r == GS_LOCKED) || (state_r == GS_KEY1) ||
                     (state_r == GS_KEY2));
    end

    // Entering the first-key state is only possible from locked.
    assert_key1_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r == GS_KEY1 && $past(state_r) != GS_KEY1) |->
        ($past(state_r) == GS_LOCKED));

    // Entering the second-key state is only possible from the first-key state.
    assert_key2_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r == GS_KEY2 && $past(state_r) != GS_KEY2) |->
        ($past(state_r) == GS_KEY1));

    // Unlocking happens only from the second-key state on a page write.
    assert_open_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_r == GS_OPEN && $past(state_r) != GS_OPEN) |->
        ($past(state_r) == GS_KEY2 && $past(page_wr)));

    // The start pulse lasts one cycle and follows the unlocked state.
    assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> ($past(state_r) == GS_OPEN && !$past(op_start)));

    // A busy machine without done holds its state.
    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_r == GS_PROG || state_r == GS_ERASE) && !op_done) |=>
        $stable(state_r));

    // The protect-select flag is only ever held while locked.
    assert_prosel_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prosel_r |-> (state_r == GS_LOCKED));

endmodule

// File: rtl/flash_access_guard.sv
// Module: top of the flash access guard. Decodes the four-location register
// window, connects the lock machine, page/protect store and divider, and
// builds the read mux with the aliased locations.
// Assumes reads are combinational on reg_addr and writes take one cycle.
module flash_access_guard
    import flash_guard_pkg::*;
#(
    parameter int PAGE_W = 7,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              flash_start,
    output logic              flash_erase,
    output logic [PAGE_W-1:0] flash_page,
    input  logic              flash_done
);

    guard_state_t      state;
    logic              prosel;
    logic              page_load;
    logic              mask_wr;
    logic              cmd_wr;
    logic              page_wr;
    logic              hi_wr;
    logic              lo_wr;
    logic [PAGE_W-1:0] page_q;
    logic [BYTE_W-1:0] mask_q;
    logic              sect_hit;
    logic [BYTE_W-1:0] div_hi;
    logic [BYTE_W-1:0] div_lo;
    logic              div_ok;

    // Decode write strobes by location.
    always_comb begin
        cmd_wr  = reg_wr && (reg_addr == LOC_CMD);
        page_wr = reg_wr && (reg_addr == LOC_PAGE);
        hi_wr   = reg_wr && (reg_addr == LOC_DIVHI);
        lo_wr   = reg_wr && (reg_addr == LOC_DIVLO);
    end

    flash_guard_fsm #(
        .PAGE_W (PAGE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .page_wr   (page_wr),
        .wdata     (reg_wdata),
        .page_q    (page_q),
        .sect_hit  (sect_hit),
        .div_ok    (div_ok),
        .op_done   (flash_done),
        .state     (state),
        .prosel    (prosel),
        .page_load (page_load),
        .mask_wr   (mask_wr),
        .op_start  (flash_start)
    );

    flash_guard_pagereg #(
        .PAGE_W (PAGE_W),
        .SECT_W (SECT_W)
    ) u_pagereg (
        .clk       (clk),
        .rst_n     (rst_n),
        .page_load (page_load),
        .mask_wr   (mask_wr),
        .wdata     (reg_wdata),
        .page_q    (page_q),
        .mask_q    (mask_q),
        .sect_hit  (sect_hit)
    );

    flash_guard_divider #(
        .DIV_W (16)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_wr  (hi_wr),
        .lo_wr  (lo_wr),
        .wdata  (reg_wdata),
        .hi_q   (div_hi),
        .lo_q   (div_lo),
        .div_ok (div_ok)
    );

    // Read mux: state code on the command location, mask or page on the
    // shared page location depending on the protect-select flag.
    always_comb begin
        case (reg_addr)
            LOC_CMD:   reg_rdata = BYTE_W'(state);
            LOC_PAGE:  reg_rdata = prosel ? mask_q : BYTE_W'(page_q);
            LOC_DIVHI: reg_rdata = div_hi;
            default:   reg_rdata = div_lo;
        endcase
    end

    // Operation outputs to the flash engine.
    always_comb begin
        flash_erase = (state == GS_ERASE);
        flash_page  = page_q;
    end

    // The state code never leaves the defined set.
    assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state <= GS_ERASE));

    // The page seen by the flash engine is stable while an operation runs.
    assert_page_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == GS_PROG || state == GS_ERASE) &&
         ($past(state) == GS_PROG || $past(state) == GS_ERASE)) |->
        $stable(flash_page));

    // A start pulse only occurs with a configured divider.
    assert_start_div_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flash_start |-> div_ok);

endmodule

// File: tb/flash_access_guard_bench.sv
module flash_access_guard_bench;

    localparam int PW = 6;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [7:0]    reg_wdata = 8'd0;
    logic [7:0]    reg_rdata;
    logic          flash_start;
    logic          flash_erase;
    logic [PW-1:0] flash_page;
    logic          flash_done = 1'b0;

    int n_run  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    flash_access_guard #(.PAGE_W(PW), .SECT_W(SW)) u_flash_access_guard (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .flash_start(flash_start), .flash_erase(flash_erase),
        .flash_page(flash_page), .flash_done(flash_done)
    );

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write one location; returns at the negedge after the capturing edge.
    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic unlock(logic [7:0] pg);
        wr(2'd1, pg);
        wr(2'd0, 8'h73);
        wr(2'd0, 8'h8C);
        wr(2'd1, pg);
    endtask

    task automatic set_div();
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h19);
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        rd(2'd0, v); chk("R1 state", v, 0);
        rd(2'd1, v); chk("R1 page", v, 0);
        rd(2'd2, v); chk("R1 divhi", v, 0);
        rd(2'd3, v); chk("R1 divlo", v, 0);
        chk("R1 start", int'(flash_start), 0);
        wr(2'd0, 8'h5E);
        rd(2'd1, v); chk("R1 mask", v, 0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_keys();
        int v;
        do_reset();
        wr(2'd0, 8'h72);
        rd(2'd0, v); chk("R2 wrong key stays locked", v, 0);
        wr(2'd0, 8'h73);
        rd(2'd0, v); chk("R2 first key", v, 1);
        wr(2'd0, 8'h8D);
        rd(2'd0, v); chk("R3 wrong second key", v, 0);
        wr(2'd0, 8'h73);
        wr(2'd1, 8'h03);
        rd(2'd0, v); chk("R3 page write in key1", v, 0);
        wr(2'd0, 8'h73);
        wr(2'd0, 8'h8C);
        rd(2'd0, v); chk("R3 second key", v, 2);
        rd(2'd0, v); chk("R6 upper bits zero", v & 8'hF8, 0);
        wr(2'd0, 8'h8C);
        rd(2'd0, v); chk("R4 cmd write in key2", v, 0);
    endtask

    task automatic t_unlock();
        int v;
        do_reset();
        unlock(8'h25);
        rd(2'd0, v); chk("R4 matching page unlocks", v, 3);
        wr(2'd1, 8'h25);
        rd(2'd0, v); chk("R12 page write when open", v, 0);
        wr(2'd1, 8'h25); wr(2'd0, 8'h73); wr(2'd0, 8'h8C); wr(2'd1, 8'h26);
        rd(2'd0, v); chk("R4 mismatch relocks", v, 0);
        unlock(8'h25);
        wr(2'd0, 8'h11);
        rd(2'd0, v); chk("R12 stray command", v, 0);
    endtask

    task automatic t_protect();
        int v;
        do_reset();
        wr(2'd1, 8'h07);
        wr(2'd0, 8'h5E);
        rd(2'd1, v); chk("R7 alias reads mask", v, 0);
        wr(2'd1, 8'h02);
        rd(2'd1, v); chk("R7 alias restores page", v, 7);
        wr(2'd0, 8'h5E);
        rd(2'd1, v); chk("R7 mask set", v, 2);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h5E);
        rd(2'd1, v); chk("R8 mask sticky", v, 2);
        wr(2'd0, 8'h00);
        rd(2'd1, v); chk("R7 page kept", v, 7);
        unlock(8'h15);
        rd(2'd0, v); chk("R5 protected sector", v, 0);
        unlock(8'h25);
        rd(2'd0, v); chk("R5 unprotected sector", v, 3);
    endtask

    task automatic t_program();
        int v;
        do_reset();
        set_div();
        rd(2'd3, v); chk("R9 divlo readback", v, 8'h19);
        unlock(8'h2A);
        wr(2'd0, 8'h4A);
        chk("R9 start pulse", int'(flash_start), 1);
        chk("R9 program not erase", int'(flash_erase), 0);
        chk("R9 page out", int'(flash_page), 8'h2A);
        rd(2'd0, v); chk("R9 program code", v, 4);
        @(negedge clk);
        chk("R9 start one cycle", int'(flash_start), 0);
        wr(2'd0, 8'h73);
        rd(2'd0, v); chk("R10 cmd ignored busy", v, 4);
        wr(2'd1, 8'h01);
        chk("R10 page ignored busy", int'(flash_page), 8'h2A);
        @(negedge clk); flash_done = 1'b1;
        @(negedge clk); flash_done = 1'b0;
        rd(2'd0, v); chk("R10 done relocks", v, 0);
    endtask

    task automatic t_erase();
        int v;
        do_reset();
        set_div();
        unlock(8'h31);
        wr(2'd0, 8'hB5);
        chk("R9 erase start", int'(flash_start), 1);
        chk("R9 erase flag", int'(flash_erase), 1);
        rd(2'd0, v); chk("R9 erase code", v, 5);
        @(negedge clk); flash_done = 1'b1;
        @(negedge clk); flash_done = 1'b0;
        rd(2'd0, v); chk("R10 erase done", v, 0);
        chk("R10 erase flag drops", int'(flash_erase), 0);
    endtask

    task automatic t_nodiv();
        int v;
        do_reset();
        unlock(8'h21);
        wr(2'd0, 8'h4A);
        chk("R11 no start", int'(flash_start), 0);
        rd(2'd0, v); chk("R11 relock", v, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_keys();
                t_unlock();
                t_protect();
                t_program();
                t_erase();
                t_nodiv();
                done_flag = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done_flag) begin
                    n_run++; n_fail++;
                    $display("FAIL watchdog actual=hung expected=done");
                end
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule